// File: doc/BRIEF.md
# Processor Reset Release Sequencer

This block governs how a bus-mastering processor core comes out of reset. An active-low external reset request, which may change at any time, is brought into the bus clock domain through a two-stage synchronizer. Once the synchronized request goes inactive, the block keeps the core in internal reset for a fixed stretch of bus clocks (128 by default). At the release it captures the mode-select pins: a cache-disable bit, a translation-disable bit and a 3-bit interrupt-level field. These captured values then set the special operating modes.

While the core is in reset, and afterwards until the bus is granted, the block holds the output enable of the three-statable bus pins low and keeps a reset-indicator status high for the whole internal reset. When a grant is sampled after the stretch, the block enables the bus pins and issues a one-cycle start pulse for the first bus cycle of reset exception processing. A new reset request at any point sends the sequencer straight back to its reset state and clears the count.

Top module: `cpu_reset_sequencer`

## Requirements
- R1: `rst_ext_n_i` passes through two synchronizer flops before the sequencer uses it. If it goes high just after rising edge k, `state_o` first shows STRETCH after rising edge k+3. A low level reaches the sequencer with the same two-edge delay.
- R2: `state_o` stays at STRETCH for exactly HOLD (128) rising edges and then moves to WAIT_GRANT. `core_rst_n_o` is 0 in RESET and in STRETCH, and 1 in WAIT_GRANT and in RUN.
- R3: `reset_ind_o` is 1 throughout RESET and STRETCH, and 0 in WAIT_GRANT and RUN.
- R4: `bus_oe_o` is 0 in every state other than RUN. A high `bus_grant_i` during RESET or STRETCH has no effect on the state or on `bus_oe_o`.
- R5: On the rising edge that moves the sequencer from RESET to STRETCH, `cache_off_i`, `mmu_off_i` and `irq_lvl_i` are captured. They appear on `cache_off_o`, `mmu_off_o` and `irq_lvl_o` from that edge on.
- R6: When the synchronized reset goes low in STRETCH, WAIT_GRANT or RUN, the state returns to RESET at the next rising edge. A later release starts a full stretch of HOLD edges.
- R7: In WAIT_GRANT, a high `bus_grant_i` at a rising edge moves the state to RUN and makes `start_o` 1 for exactly the following cycle. `start_o` is 0 at all other times.
- R8: The captured mode outputs keep their value until the next RESET-to-STRETCH transition, whatever the mode pins do after capture.
- R9: `state_o` encodes RESET=0, STRETCH=1, WAIT_GRANT=2 and RUN=3. RUN is left only through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ext_n_i | input | 1 | Asynchronous active-low external reset request |
| cache_off_i | input | 1 | Cache-disable mode pin |
| mmu_off_i | input | 1 | Translation-disable mode pin |
| irq_lvl_i | input | 3 | Interrupt-level mode field |
| bus_grant_i | input | 1 | Bus grant from the arbiter |
| core_rst_n_o | output | 1 | Internal core reset, active low |
| reset_ind_o | output | 1 | Status, high while the core is in reset |
| bus_oe_o | output | 1 | Output enable for the three-statable bus pins |
| start_o | output | 1 | One-cycle start of the first exception bus cycle |
| cache_off_o | output | 1 | Captured cache-disable mode |
| mmu_off_o | output | 1 | Captured translation-disable mode |
| irq_lvl_o | output | 3 | Captured interrupt-level field |
| state_o | output | 2 | Current sequencer state |

## Verification
A change on the external reset reaches `state_o` three rising edges later: two synchronizer stages, then the state register. A grant sampled in WAIT_GRANT shows as RUN and `start_o` one edge later, and the stretch ends on the 128th edge after entry. The bench's reference model keeps the reset history in a two-entry queue, so the model sees each level with the same delay. It advances on every rising edge and compares every output at the following falling edge. Directed checks count falling edges from each stimulus to the expected change, and those counts are fixed by this same latency.

// File: rtl/rstseq_pkg.sv
// Package: shared types for the reset release sequencer.
// Assumes: the encoding below is visible on the state output and is relied on by users.
package rstseq_pkg;

    typedef enum logic [1:0] {
        SEQ_RESET    = 2'd0,
        SEQ_STRETCH  = 2'd1,
        SEQ_WAIT_GNT = 2'd2,
        SEQ_RUN      = 2'd3
    } seq_state_e;

    localparam int IRQ_W = 3;

    typedef struct packed {
        logic             cache_off;
        logic             mmu_off;
        logic [IRQ_W-1:0] irq_lvl;
    } mode_cfg_t;

endpackage

// File: rtl/rstseq_sync.sv
// Module: level synchronizer for the external reset request.
// Does: shifts the asynchronous input through STAGES flops clocked by clk_i.
// Assumes: STAGES >= 2; the flops carry no reset, since they carry the reset itself.
module rstseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic async_n_i,
    output logic sync_n_o
);

    logic [STAGES-1:0] chain_q;

    // Capture stage: first contact with the asynchronous input.
    always_ff @(posedge clk_i) begin
        chain_q[0] <= async_n_i;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            // Settle stage: pass the level one flop further down.
            always_ff @(posedge clk_i) begin
                chain_q[g] <= chain_q[g-1];
            end
        end
    endgenerate

    assign sync_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/rstseq_stretch_cnt.sv
// Module: down-counter that times the internal reset stretch.
// Does: loads HOLD on load_i and counts down while dec_i is high. last_o flags the
// final count, so the owner leaves the stretch on the edge where the count hits zero.
// Assumes: HOLD >= 1; the synchronous reset is active low.
module rstseq_stretch_cnt #(
    parameter int HOLD = 128
) (
    input  logic clk_i,
    input  logic srst_n_i,
    input  logic load_i,
    input  logic dec_i,
    output logic last_o
);

    localparam int CNT_W = $clog2(HOLD + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(HOLD);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // Count register: cleared by reset, loaded at release, decremented during the stretch.
    always_ff @(posedge clk_i) begin
        if (!srst_n_i) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= LOAD_VAL;
        end else if (dec_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign last_o = (cnt_q == ONE);

endmodule

// File: rtl/rstseq_mode_latch.sv
// Module: capture register for the mode-select pins.
// Does: samples the pins on capture_i and holds them until the next capture.
// Assumes: the pins are stable around the capture edge. No reset, so the value
// survives later resets until the next release.
module rstseq_mode_latch
    import rstseq_pkg::*;
(
    input  logic      clk_i,
    input  logic      capture_i,
    input  mode_cfg_t pins_i,
    output mode_cfg_t cfg_o
);

    mode_cfg_t cfg_q;

    // Mode hold: take a new copy only at the release edge.
    always_ff @(posedge clk_i) begin
        if (capture_i) begin
            cfg_q <= pins_i;
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/rstseq_fsm.sv
// Module: state machine of the reset release sequence.
// Does: walks RESET -> STRETCH -> WAIT_GRANT -> RUN and raises a one-cycle start
// pulse on entry to RUN.
// Assumes: srst_n_i is already synchronized to clk_i; it is an active-low synchronous reset.
module rstseq_fsm
    import rstseq_pkg::*;
(
    input  logic       clk_i,
    input  logic       srst_n_i,
    input  logic       grant_i,
    input  logic       cnt_last_i,
    output seq_state_e state_o,
    output logic       load_o,
    output logic       dec_o,
    output logic       start_o
);

    seq_state_e state_q;
    seq_state_e state_d;
    logic       start_q;

    // Next-state choice for each phase of the release.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_RESET:    state_d = SEQ_STRETCH;
            SEQ_STRETCH:  if (cnt_last_i) state_d = SEQ_WAIT_GNT;
            SEQ_WAIT_GNT: if (grant_i)    state_d = SEQ_RUN;
            SEQ_RUN:      state_d = SEQ_RUN;
            default:      state_d = SEQ_RESET;
        endcase
    end

    // State and start-pulse registers under synchronous reset.
    always_ff @(posedge clk_i) begin
        if (!srst_n_i) begin
            state_q <= SEQ_RESET;
            start_q <= 1'b0;
        end else begin
            state_q <= state_d;
            start_q <= (state_q == SEQ_WAIT_GNT) && grant_i;
        end
    end

    assign state_o = state_q;
    assign load_o  = srst_n_i && (state_q == SEQ_RESET);
    assign dec_o   = (state_q == SEQ_STRETCH);
    assign start_o = start_q;

endmodule

// File: rtl/cpu_reset_sequencer.sv
// Module: top of the processor reset release sequencer.
// Does: synchronizes the external reset, stretches the internal reset by HOLD
// clocks, captures the mode pins at release, keeps the bus pins disabled until a
// grant, then issues the start pulse of the first exception bus cycle.
// Assumes: a single bus clock; bus_grant_i is synchronous to clk_i.
module cpu_reset_sequencer
    import rstseq_pkg::*;
#(
    parameter int HOLD        = 128,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ext_n_i,
    input  logic             cache_off_i,
    input  logic             mmu_off_i,
    input  logic [IRQ_W-1:0] irq_lvl_i,
    input  logic             bus_grant_i,
    output logic             core_rst_n_o,
    output logic             reset_ind_o,
    output logic             bus_oe_o,
    output logic             start_o,
    output logic             cache_off_o,
    output logic             mmu_off_o,
    output logic [IRQ_W-1:0] irq_lvl_o,
    output logic [1:0]       state_o
);

    logic       rst_sync_n;
    logic       cnt_load;
    logic       cnt_dec;
    logic       cnt_last;
    seq_state_e seq_state;
    mode_cfg_t  pins;
    mode_cfg_t  cfg;

    rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i     (clk_i),
        .async_n_i (rst_ext_n_i),
        .sync_n_o  (rst_sync_n)
    );

    rstseq_stretch_cnt #(.HOLD(HOLD)) u_cnt (
        .clk_i    (clk_i),
        .srst_n_i (rst_sync_n),
        .load_i   (cnt_load),
        .dec_i    (cnt_dec),
        .last_o   (cnt_last)
    );

    rstseq_fsm u_fsm (
        .clk_i      (clk_i),
        .srst_n_i   (rst_sync_n),
        .grant_i    (bus_grant_i),
        .cnt_last_i (cnt_last),
        .state_o    (seq_state),
        .load_o     (cnt_load),
        .dec_o      (cnt_dec),
        .start_o    (start_o)
    );

    assign pins = '{cache_off: cache_off_i, mmu_off: mmu_off_i, irq_lvl: irq_lvl_i};

    rstseq_mode_latch u_mode (
        .clk_i     (clk_i),
        .capture_i (cnt_load),
        .pins_i    (pins),
        .cfg_o     (cfg)
    );

    // Output decode: reset view and bus enable follow the registered state.
    always_comb begin
        core_rst_n_o = (seq_state == SEQ_WAIT_GNT) || (seq_state == SEQ_RUN);
        reset_ind_o  = (seq_state == SEQ_RESET) || (seq_state == SEQ_STRETCH);
        bus_oe_o     = (seq_state == SEQ_RUN);
    end

    assign state_o     = seq_state;
    assign cache_off_o = cfg.cache_off;
    assign mmu_off_o   = cfg.mmu_off;
    assign irq_lvl_o   = cfg.irq_lvl;

endmodule

// File: rtl/rstseq_checker.sv
// Module: property checker for cpu_reset_sequencer, attached by bind.
// Does: checks the stretch length with a local counter and the output rules across states.
// Assumes: rst_sync_n is the synchronized reset inside the top module.
module rstseq_checker
    import rstseq_pkg::*;
#(
    parameter int HOLD = 128
) (
    input logic       clk_i,
    input logic       rst_sync_n,
    input logic       bus_grant_i,
    input logic       core_rst_n_o,
    input logic       reset_ind_o,
    input logic       bus_oe_o,
    input logic       start_o,
    input logic       cache_off_o,
    input logic       mmu_off_o,
    input logic [2:0] irq_lvl_o,
    input logic [1:0] state_o
);

    localparam int SW = $clog2(HOLD + 2);

    logic [SW-1:0] stretch_q;
    logic          armed_q;

    // Stretch length counter, cleared outside STRETCH.
    always_ff @(posedge clk_i) begin
        if (state_o == SEQ_STRETCH) stretch_q <= stretch_q + SW'(1);
        else                        stretch_q <= '0;
    end

    // Arm flag: set once the synchronized reset has been seen low.
    always_ff @(posedge clk_i) begin
        if (rst_sync_n == 1'b0) armed_q <= 1'b1;
        else if (armed_q !== 1'b1) armed_q <= 1'b0;
    end

    AST_STRETCH_LEN: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
        (state_o == SEQ_WAIT_GNT && $past(state_o) == SEQ_STRETCH) |-> stretch_q == SW'(HOLD)); // R2
    AST_NO_OVERRUN: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
        stretch_q <= SW'(HOLD)); // R2
    AST_IND_IN_STRETCH: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
        (state_o == SEQ_STRETCH) |-> (reset_ind_o && !core_rst_n_o)); // R3
    AST_BUS_HIZ: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
        (state_o != SEQ_RUN) |-> !bus_oe_o); // R4
    AST_START_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
        start_o |-> ($past(state_o) == SEQ_WAIT_GNT && $past(bus_grant_i) && state_o == SEQ_RUN)); // R7
    AST_START_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
        start_o |=> !start_o); // R7
    AST_MODE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
        (state_o != SEQ_RESET && $past(state_o) != SEQ_RESET)
        |-> ($stable(cache_off_o) && $stable(mmu_off_o) && $stable(irq_lvl_o))); // R8
    AST_REASSERT: assert property (@(posedge clk_i) disable iff (!armed_q)
        !rst_sync_n |=> (state_o == SEQ_RESET)); // R6
    AST_RUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
        (state_o == SEQ_RUN) |=> (state_o == SEQ_RUN)); // R9

endmodule

bind cpu_reset_sequencer rstseq_checker #(.HOLD(HOLD)) u_rstseq_chk (
    .clk_i        (clk_i),
    .rst_sync_n   (rst_sync_n),
    .bus_grant_i  (bus_grant_i),
    .core_rst_n_o (core_rst_n_o),
    .reset_ind_o  (reset_ind_o),
    .bus_oe_o     (bus_oe_o),
    .start_o      (start_o),
    .cache_off_o  (cache_off_o),
    .mmu_off_o    (mmu_off_o),
    .irq_lvl_o    (irq_lvl_o),
    .state_o      (state_o)
);

// File: tb/cpu_reset_sequencer_tb_top.sv
`timescale 1ns/1ps
module cpu_reset_sequencer_tb_top;

    localparam int HOLD = 128;

    logic       clk = 1'b0;
    logic       rst_ext_n = 1'b0;
    logic       cache_off = 1'b0;
    logic       mmu_off = 1'b0;
    logic [2:0] irq_lvl = 3'd0;
    logic       grant = 1'b0;
    logic       core_rst_n, reset_ind, bus_oe, start, cache_off_q, mmu_off_q;
    logic [2:0] irq_lvl_q;
    logic [1:0] state;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cpu_reset_sequencer #(.HOLD(HOLD)) dut_i (
        .clk_i(clk), .rst_ext_n_i(rst_ext_n), .cache_off_i(cache_off),
        .mmu_off_i(mmu_off), .irq_lvl_i(irq_lvl), .bus_grant_i(grant),
        .core_rst_n_o(core_rst_n), .reset_ind_o(reset_ind), .bus_oe_o(bus_oe),
        .start_o(start), .cache_off_o(cache_off_q), .mmu_off_o(mmu_off_q),
        .irq_lvl_o(irq_lvl_q), .state_o(state)
    );

    task automatic chk(string tag, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_errors++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    // Reference model: reset history queue, phase number, remaining count.
    int  rq[$] = '{0, 0};
    int  m_phase = 0;
    int  m_left = 0;
    int  m_start = 0;
    int  m_mode = 0;
    bit  m_valid = 0;
    bit  m_mode_valid = 0;

    always @(posedge clk) begin
        int seen;
        seen = rq[0];
        void'(rq.pop_front());
        rq.push_back(int'(rst_ext_n));
        m_start = 0;
        if (seen == 0) begin
            m_phase = 0;
            m_left = 0;
            m_valid = 1;
        end else if (m_valid) begin
            if (m_phase == 0) begin
                m_phase = 1;
                m_left = HOLD;
                m_mode = {cache_off, mmu_off, irq_lvl};
                m_mode_valid = 1;
            end else if (m_phase == 1) begin
                m_left--;
                if (m_left == 0) m_phase = 2;
            end else if (m_phase == 2) begin
                if (grant) begin
                    m_phase = 3;
                    m_start = 1;
                end
            end
        end
    end

    // Per-cycle comparison at the falling edge.
    always @(negedge clk) begin
        if (m_valid && !done) begin
            chk("R9 state", state, m_phase);
            chk("R2 core_rst_n", core_rst_n, (m_phase >= 2) ? 1 : 0);
            chk("R3 reset_ind", reset_ind, (m_phase <= 1) ? 1 : 0);
            chk("R4 bus_oe", bus_oe, (m_phase == 3) ? 1 : 0);
            chk("R7 start", start, m_start);
            if (m_mode_valid) chk("R5 modes", {cache_off_q, mmu_off_q, irq_lvl_q}, m_mode);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic stretch_len(string tag);
        int len = 0;
        while (state != 2'd1) @(negedge clk);
        while (state == 2'd1) begin
            len++;
            @(negedge clk);
        end
        chk(tag, len, HOLD);
    endtask

    initial begin
        cache_off = 1'b1; mmu_off = 1'b0; irq_lvl = 3'b101;
        cyc(6);
        chk("R1 reset state", state, 0);
        chk("R4 oe in reset", bus_oe, 0);
        chk("R3 ind in reset", reset_ind, 1);
        // R1: release after an edge; STRETCH appears after the third edge.
        rst_ext_n = 1'b1;
        cyc(2);
        chk("R1 still reset after two edges", state, 0);
        cyc(1);
        chk("R1 stretch after three edges", state, 1);
        // R8: change pins after capture; R4: grant during stretch ignored.
        cache_off = 1'b0; mmu_off = 1'b1; irq_lvl = 3'b010; grant = 1'b1;
        cyc(10);
        chk("R4 grant ignored in stretch", state, 1);
        chk("R4 oe low with grant in stretch", bus_oe, 0);
        grant = 1'b0;
        while (state == 2'd1) @(negedge clk);
        chk("R2 wait grant reached", state, 2);
        chk("R8 mode kept", {cache_off_q, mmu_off_q, irq_lvl_q}, 6'b10_101);
        cyc(5);
        chk("R4 oe low in wait", bus_oe, 0);
        grant = 1'b1;
        cyc(1);
        chk("R7 run after grant", state, 3);
        chk("R7 start pulse", start, 1);
        grant = 1'b0;
        cyc(1);
        chk("R7 start single", start, 0);
        chk("R4 oe in run", bus_oe, 1);
        // R6: reset from RUN.
        rst_ext_n = 1'b0;
        cyc(3);
        chk("R6 reset from run", state, 0);
        cyc(2);
        // New modes; R6 reset mid-stretch, then a full stretch.
        cache_off = 1'b1; mmu_off = 1'b1; irq_lvl = 3'b111;
        rst_ext_n = 1'b1;
        cyc(53);
        chk("R6 in stretch before abort", state, 1);
        rst_ext_n = 1'b0;
        cyc(3);
        chk("R6 abort stretch", state, 0);
        irq_lvl = 3'b011;
        rst_ext_n = 1'b1;
        stretch_len("R6 full stretch after abort");
        chk("R5 new capture", {cache_off_q, mmu_off_q, irq_lvl_q}, 6'b11_011);
        // R6: reset while waiting for the grant.
        cyc(4);
        rst_ext_n = 1'b0;
        cyc(3);
        chk("R6 abort wait", state, 0);
        // Grant held high before the stretch ends: RUN right after.
        cache_off = 1'b0; mmu_off = 1'b0; irq_lvl = 3'b001;
        rst_ext_n = 1'b1;
        grant = 1'b1;
        stretch_len("R2 stretch length");
        chk("R7 wait with grant", state, 2);
        cyc(1);
        chk("R7 run at once", state, 3);
        chk("R7 pulse at once", start, 1);
        cyc(4);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule